// File: doc/BRIEF.md
# A20 Gate and Fast Processor Init Control Register

This block is a single 8-bit system control register reached over a plain I/O-mapped host port (address, write strobe, read strobe, write data, read data). Two bits of it matter. The fast-A20 bit is merged with the gate line from the keyboard controller to form the active-low mask for address bit 20 that goes to the processor. While that bit is set, the mask is held released. While it is clear, the keyboard gate alone decides the mask.

The fast-init bit gives software a quick way to reset the processor, for example to leave protected mode. Writing a one to it, when it currently holds zero, sends a fixed-length active-high init pulse of 16 clocks. The bit keeps reading one after the pulse ends. Another pulse only becomes possible once software has written the bit back to zero. All other bits of the register are reserved and read as zero. The bus front end and the keyboard controller sit outside this block.

Top module: `sysctl_a20_init`

## Requirements
- R1: A synchronous active-high reset clears the register to 00h, holds `cpu_init` low and leaves `a20_mask_n` following `kbc_gate`.
- R2: With `io_rd` high and `io_addr` equal to 0092h, `io_rdata` returns the fast-A20 bit at bit 1, the fast-init bit at bit 0 and zeros in bits 7..2. In every other cycle `io_rdata` is 00h.
- R3: A write to any address other than 0092h changes neither the register, nor `cpu_init`, nor `a20_mask_n`.
- R4: `a20_mask_n` is high whenever the fast-A20 bit (bit 1) is 1 or `kbc_gate` is high. It is low only when both are 0. It follows `kbc_gate` in the same cycle.
- R5: A write with data bit 0 = 1 while the fast-init bit holds 0 raises `cpu_init` in the cycle after the write. It stays high for exactly 16 cycles.
- R6: A write with data bit 0 = 1 while the fast-init bit already holds 1 neither starts nor extends a pulse.
- R7: A write of 0 to bit 0 during a pulse does not shorten it. A following write of 1 reloads the full 16-cycle length, even in the cycle the running pulse would have ended.
- R8: Reset during a pulse drops `cpu_init` in the next cycle and re-arms the init function, so the next write of 1 pulses again.
- R9: Bits 1 and 0 read back the value last written. Bit 0 still reads 1 after its pulse has ended.
- R10: A read in the same cycle as a write returns the register contents from before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| io_addr | input | 16 | I/O address of the current access |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational, zero when not selected |
| kbc_gate | input | 1 | A20 gate from the keyboard controller, high = enable |
| a20_mask_n | output | 1 | Address bit 20 mask to the processor, active low |
| cpu_init | output | 1 | Processor init pulse, active high |

## Verification
Three collisions are provoked deliberately.

- **Re-arm at pulse expiry:** a write of zero followed by a write of one is timed so that the second write lands on the same clock edge at which the running pulse's counter reaches its last count. The reload must win, and `cpu_init` must not dip for even one cycle.
- **Read during write:** a read and a write are issued in the same cycle, and the returned data must equal the old contents.
- **Reset during a pulse:** reset is asserted part-way through a pulse.

In all three cases a behavioural model in the bench predicts each cycle's `cpu_init`, `a20_mask_n` and `io_rdata`, and these are compared every cycle.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    // Bit positions inside the control register (software visible layout)
    localparam int A20_BIT  = 1;
    localparam int INIT_BIT = 0;

    typedef struct packed {
        logic fast_a20;
        logic init_bit;
    } ctl_t;

endpackage

// File: rtl/io_decode.sv
module io_decode #(
    parameter int ADDR_W   = 16,
    parameter int REG_ADDR = 'h92
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output logic              wr_hit,
    output logic              rd_hit
);
    localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(REG_ADDR);

    logic sel;

    always_comb begin
        sel    = (addr == MATCH);
        wr_hit = wr & sel;
        rd_hit = rd & sel;
    end
endmodule

// File: rtl/a20_combine.sv
module a20_combine (
    input  logic fast_a20,
    input  logic gate,
    output logic mask_n
);
    // Mask is asserted (low) only when neither source enables bit 20
    always_comb begin
        mask_n = fast_a20 | gate;
    end
endmodule

// File: rtl/init_pulse.sv
module init_pulse #(
    parameter int PULSE_LEN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic pulse
);
    localparam int CNT_W = (PULSE_LEN > 2) ? $clog2(PULSE_LEN) : 1;
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_LEN - 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] left;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (start) begin
            tmr_d.busy = 1'b1;
            tmr_d.left = LOAD;
        end else if (tmr_q.busy) begin
            if (tmr_q.left == '0) begin
                tmr_d.busy = 1'b0;
            end else begin
                tmr_d.left = tmr_q.left - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign pulse = tmr_q.busy;
endmodule

// File: rtl/sysctl_a20_init.sv
module sysctl_a20_init
    import sysctl_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int REG_ADDR  = 'h92,
    parameter int PULSE_LEN = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    input  logic              kbc_gate,
    output logic              a20_mask_n,
    output logic              cpu_init
);
    logic wr_hit;
    logic rd_hit;
    logic fire;
    ctl_t ctl_d, ctl_q;

    io_decode #(
        .ADDR_W   (ADDR_W),
        .REG_ADDR (REG_ADDR)
    ) u_dec (
        .addr   (io_addr),
        .wr     (io_wr),
        .rd     (io_rd),
        .wr_hit (wr_hit),
        .rd_hit (rd_hit)
    );

    // Next register value; a pulse fires only on a 0-to-1 change of the init bit
    always_comb begin
        ctl_d = ctl_q;
        fire  = 1'b0;
        if (wr_hit) begin
            fire           = io_wdata[INIT_BIT] & ~ctl_q.init_bit;
            ctl_d.fast_a20 = io_wdata[A20_BIT];
            ctl_d.init_bit = io_wdata[INIT_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // Readback: reserved bits zero, data only while selected
    always_comb begin
        io_rdata = '0;
        if (rd_hit) begin
            io_rdata[A20_BIT]  = ctl_q.fast_a20;
            io_rdata[INIT_BIT] = ctl_q.init_bit;
        end
    end

    a20_combine u_a20 (
        .fast_a20 (ctl_q.fast_a20),
        .gate     (kbc_gate),
        .mask_n   (a20_mask_n)
    );

    init_pulse #(
        .PULSE_LEN (PULSE_LEN)
    ) u_pulse (
        .clk   (clk),
        .rst   (rst),
        .start (fire),
        .pulse (cpu_init)
    );
endmodule

// File: rtl/a20_init_chk.sv
module a20_init_chk #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int REG_ADDR  = 'h92,
    parameter int PULSE_LEN = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_wr,
    input logic              io_rd,
    input logic [DATA_W-1:0] io_wdata,
    input logic [DATA_W-1:0] io_rdata,
    input logic              kbc_gate,
    input logic              a20_mask_n,
    input logic              cpu_init
);
    localparam int RUN_W = $clog2(PULSE_LEN + 2) + 1;

    logic             set_wr;
    logic [RUN_W-1:0] run_q;

    assign set_wr = io_wr && (io_addr == ADDR_W'(REG_ADDR)) && io_wdata[0];

    // Cycles of init already seen since the last write that could (re)start it
    always_ff @(posedge clk) begin
        if (rst || set_wr || !cpu_init) begin
            run_q <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    // R5
    pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_init |-> (run_q < RUN_W'(PULSE_LEN)));

    // R6
    pulse_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_init) |-> $past(set_wr));

    // R4
    gate_release_chk: assert property (@(posedge clk) disable iff (rst)
        kbc_gate |-> a20_mask_n);

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        io_rdata[DATA_W-1:2] == '0);

    // R2
    idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
        !io_rd |-> (io_rdata == '0));

    // R8
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !cpu_init);
endmodule

bind sysctl_a20_init a20_init_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .REG_ADDR  (REG_ADDR),
    .PULSE_LEN (PULSE_LEN)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .io_addr    (io_addr),
    .io_wr      (io_wr),
    .io_rd      (io_rd),
    .io_wdata   (io_wdata),
    .io_rdata   (io_rdata),
    .kbc_gate   (kbc_gate),
    .a20_mask_n (a20_mask_n),
    .cpu_init   (cpu_init)
);

// File: tb/sysctl_a20_init_test.sv
`timescale 1ns/1ps
module sysctl_a20_init_test;
    localparam logic [15:0] REG = 16'h0092;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        kbc_gate = 1'b0;
    logic        a20_mask_n;
    logic        cpu_init;

    int    n_checks = 0;
    int    n_err = 0;
    bit    done = 0;
    string phase = "R1";

    int m_fast = 0, m_init = 0, m_left = 0;
    int hi_run = 0, last_run = 0;

    always #2 clk = ~clk;

    sysctl_a20_init uut (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .kbc_gate(kbc_gate),
        .a20_mask_n(a20_mask_n), .cpu_init(cpu_init)
    );

    task automatic check(string what, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: got %0h expected %0h", phase, what, act, exp);
        end
    endtask

    // Reference model: state advances at each rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_fast = 0; m_init = 0; m_left = 0;
        end else begin
            if (m_left > 0) m_left--;
            if (io_wr && io_addr == REG) begin
                if (io_wdata[0] && m_init == 0) m_left = 16;
                m_fast = io_wdata[1];
                m_init = io_wdata[0];
            end
        end
    end

    // Compare every cycle at the falling edge
    always @(negedge clk) begin
        if (!done) begin
            logic [7:0] exp_rd;
            exp_rd = (io_rd && io_addr == REG) ? 8'(m_fast * 2 + m_init) : 8'h00;
            check("cpu_init", {7'b0, cpu_init}, {7'b0, (m_left > 0)});
            check("a20_mask_n", {7'b0, a20_mask_n}, {7'b0, (m_fast != 0) || kbc_gate});
            check("io_rdata", io_rdata, exp_rd);
            if (cpu_init) hi_run++;
            else begin
                if (hi_run != 0) last_run = hi_run;
                hi_run = 0;
            end
        end
    end

    task automatic access(logic [15:0] a, logic w, logic r, logic [7:0] d);
        io_addr = a; io_wr = w; io_rd = r; io_wdata = d;
        @(posedge clk); #1;
        io_addr = '0; io_wr = 1'b0; io_rd = 1'b0; io_wdata = '0;
    endtask

    task automatic idle(int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic finish_run();
        done = 1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_err++;
            $display("FAIL %s watchdog: got timeout expected completion", phase);
            finish_run();
        end
    end

    initial begin
        // R1: reset state
        phase = "R1";
        idle(3);
        kbc_gate = 1'b1; idle(1); kbc_gate = 1'b0; idle(1);
        rst = 1'b0;
        idle(2);

        // R2: readback with reserved bits zero, other address reads zero
        phase = "R2";
        access(REG, 0, 1, 8'h00);
        access(16'h0093, 0, 1, 8'h00);
        access(REG, 1, 0, 8'hFE);
        access(REG, 0, 1, 8'h00);
        access(16'h0192, 0, 1, 8'h00);

        // R3: other addresses ignored
        phase = "R3";
        access(REG, 1, 0, 8'h00);
        access(16'h0093, 1, 0, 8'hFF);
        access(16'h8092, 1, 0, 8'h03);
        idle(3);
        access(REG, 0, 1, 8'h00);

        // R4: combining of fast-A20 with the gate
        phase = "R4";
        for (int b = 0; b < 2; b++) begin
            access(REG, 1, 0, 8'(b * 2));
            for (int g = 0; g < 2; g++) begin
                kbc_gate = g[0];
                idle(2);
            end
        end
        kbc_gate = 1'b0;
        access(REG, 1, 0, 8'h00);

        // R5: pulse of exactly 16 cycles
        phase = "R5";
        access(REG, 1, 0, 8'h01);
        idle(20);
        n_checks++;
        if (last_run != 16) begin
            n_err++;
            $display("FAIL R5 pulse length: got %0d expected 16", last_run);
        end

        // R9: bit 0 still set after the pulse
        phase = "R9";
        access(REG, 0, 1, 8'h00);
        access(REG, 1, 0, 8'h03);
        access(REG, 0, 1, 8'h00);

        // R6: writing 1 over 1 does nothing
        phase = "R6";
        access(REG, 1, 0, 8'h01);
        idle(20);
        access(REG, 0, 1, 8'h00);

        // R7: clear during pulse keeps it, re-set reloads, also at expiry edge
        phase = "R7";
        access(REG, 1, 0, 8'h00);
        access(REG, 1, 0, 8'h01);
        idle(5);
        access(REG, 1, 0, 8'h00);
        idle(3);
        access(REG, 1, 0, 8'h01);
        idle(14);
        access(REG, 1, 0, 8'h00);
        access(REG, 1, 0, 8'h01);
        idle(20);

        // R10: read in the same cycle as a write sees the old value
        phase = "R10";
        access(REG, 1, 1, 8'h02);
        access(REG, 1, 1, 8'h00);
        access(REG, 0, 1, 8'h00);

        // R8: reset during a pulse, then the function is armed again
        phase = "R8";
        access(REG, 1, 0, 8'h03);
        idle(4);
        rst = 1'b1; idle(1); rst = 1'b0;
        idle(2);
        access(REG, 0, 1, 8'h00);
        access(REG, 1, 0, 8'h01);
        idle(20);

        finish_run();
    end
endmodule